// File: doc/BRIEF.md
# Timed Debounce Filter

This block turns a single-bit input that bounces around its transitions into a clean level. The input is assumed to be already synchronous to the 100 MHz system clock. A new level is accepted only after the input has held it for a full settle interval of 5 ms. That interval is 500,000 clock cycles and is set by a parameter that a bench can shrink. Both rising and falling transitions are filtered the same way.

Inside, a four-state controller works with a settle timer. In its two resting states the controller holds the timer cleared. When the input disagrees with the accepted level, the controller moves to a waiting state and releases the timer. The timer then counts on every clock, with no enable. If the input stays at the new level until the timer reports completion, the controller commits the new level. If the input goes back first, the controller returns to rest and the timer is cleared again. Only the controller ever clears the timer; the global reset does not reach it directly.

Top module: `dbn_filter`

## Requirements
- R1: The reset is synchronous and active high. The first rising edge with `rst` high drives `clean_out` to 0, and `clean_out` stays 0 for as long as `rst` is high, whatever `noisy_in` does.
- R2: `clean_out` goes from 0 to 1 on the rising edge at which `noisy_in` has been sampled high on SETTLE_CYCLES+1 consecutive rising edges. The waiting state therefore lasts exactly SETTLE_CYCLES cycles, which is 500,000 cycles or 5 ms at the default.
- R3: A high run of SETTLE_CYCLES samples or fewer, starting from a stable low, leaves `clean_out` at 0.
- R4: `clean_out` goes from 1 to 0 on the rising edge at which `noisy_in` has been sampled low on SETTLE_CYCLES+1 consecutive rising edges.
- R5: A low run of SETTLE_CYCLES samples or fewer, starting from a stable high, leaves `clean_out` at 1.
- R6: A single sample back at the accepted level during a wait ends the wait. The next departure must then last the full interval again, with no credit for the earlier samples.
- R7: The settle timer is cleared only by the controller. It advances on every cycle in which its clear is low, and it flags done when it has counted SETTLE_CYCLES-1 since the clear was released. After reset is released, a level must again qualify over the full interval.
- R8: `clean_out` is a register output. It changes only on an edge at which the timer's done flag is high, or through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset of the controller |
| noisy_in | input | 1 | Bouncing input, already synchronous to clk |
| clean_out | output | 1 | Debounced level, registered |

## Verification
The settle interval is shortened to eight cycles. The input is then driven with runs of exactly the interval length and of one cycle longer, in both directions. This separates an off-by-one in the timer or the controller from a correct commit edge. A departure broken by a one-cycle return, followed by a run that would only qualify with credit from before the break, shows whether the timer really restarts. Reset is applied while the output is high and the input stays high through the release. This shows that the output drops at once and that the level must qualify again over the full interval.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  typedef enum logic [1:0] {
    ST_REST_LO = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_REST_HI = 2'd2,
    ST_WAIT_LO = 2'd3
  } dbn_state_e;
endpackage

// File: rtl/dbn_settle_timer.sv
module dbn_settle_timer #(
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic clk,
  input  logic clr,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] count_q;

  // No reset: the controller owns the clear.
  always_ff @(posedge clk) begin
    if (clr) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  assign done = (count_q == LAST);
endmodule

// File: rtl/dbn_ctrl.sv
module dbn_ctrl
  import dbn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic noisy,
  input  logic tmr_done,
  output logic tmr_clr,
  output logic level
);
  dbn_state_e state_q, state_d;
  logic       level_q, level_d;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    unique case (state_q)
      ST_REST_LO: if (noisy) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (!noisy) state_d = ST_REST_LO;
        else if (tmr_done) begin
          state_d = ST_REST_HI;
          level_d = 1'b1;
        end
      end
      ST_REST_HI: if (!noisy) state_d = ST_WAIT_LO;
      ST_WAIT_LO: begin
        if (noisy) state_d = ST_REST_HI;
        else if (tmr_done) begin
          state_d = ST_REST_LO;
          level_d = 1'b0;
        end
      end
      default: begin
        state_d = ST_REST_LO;
        level_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_REST_LO;
      level_q <= 1'b0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
    end
  end

  assign tmr_clr = (state_q == ST_REST_LO) || (state_q == ST_REST_HI);
  assign level   = level_q;

  AST_RST_FORCES_LOW: assert property (@(posedge clk) rst |=> !level); // R1
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter #(
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic noisy_in,
  output logic clean_out
);
  logic tmr_clr;
  logic tmr_done;

  dbn_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .noisy    (noisy_in),
    .tmr_done (tmr_done),
    .tmr_clr  (tmr_clr),
    .level    (clean_out)
  );

  dbn_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .clr  (tmr_clr),
    .done (tmr_done)
  );

  AST_CLEAR_KILLS_DONE: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> !tmr_done); // R7
  AST_DONE_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    (tmr_done && !tmr_clr) |=> tmr_clr); // R6
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
    !tmr_done |=> $stable(clean_out)); // R8
  AST_CHANGE_NEEDS_NOISY: assert property (@(posedge clk) disable iff (rst)
    (tmr_done && !tmr_clr && (noisy_in != clean_out)) |=> (clean_out == $past(noisy_in))); // R2
endmodule

// File: tb/sim_dbn_filter.sv
module sim_dbn_filter;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic noisy_in = 1'b0;
  logic clean_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbn_filter #(.SETTLE_CYCLES(P)) u0 (
    .clk       (clk),
    .rst       (rst),
    .noisy_in  (noisy_in),
    .clean_out (clean_out)
  );

  // {level, hold cycles[3:0], expected clean_out after hold}
  localparam logic [5:0] VEC [0:11] = '{
    {1'b1, 4'd8, 1'b0},  // R3 high run of exactly P
    {1'b0, 4'd3, 1'b0},  // R3
    {1'b1, 4'd9, 1'b1},  // R2 P+1 samples commit
    {1'b0, 4'd8, 1'b1},  // R5 low run of exactly P
    {1'b1, 4'd2, 1'b1},  // R5
    {1'b0, 4'd9, 1'b0},  // R4 P+1 samples commit
    {1'b1, 4'd4, 1'b0},  // R6 partial wait
    {1'b0, 4'd1, 1'b0},  // R6 one-cycle return
    {1'b1, 4'd8, 1'b0},  // R6 no credit kept
    {1'b1, 4'd1, 1'b1},  // R6 full run now commits
    {1'b0, 4'd5, 1'b1},  // R6 partial low wait
    {1'b1, 4'd1, 1'b1}   // R6 return high
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clean_out actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    noisy_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run state actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", clean_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      hold(VEC[i][5], int'(VEC[i][4:1]));
      check($sformatf("R2-R6 vector %0d", i), clean_out, VEC[i][0]);
    end

    // R4 with the earlier partial wait discarded: needs P+1 fresh low samples
    hold(1'b0, 8);
    check("R4 exact P low", clean_out, 1'b1);
    hold(1'b0, 1);
    check("R4 commit low", clean_out, 1'b0);

    // R1 reset while high, input stays high through release
    hold(1'b1, 9);
    check("R2 commit high", clean_out, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset drops output", clean_out, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 held in reset", clean_out, 1'b0);
    rst = 1'b0;
    hold(1'b1, 8);
    check("R7 requalify after reset", clean_out, 1'b0);
    hold(1'b1, 1);
    check("R7 commit after reset", clean_out, 1'b1);

    // R8 output steady on every cycle of a sub-interval low run
    noisy_in = 1'b0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      check("R8 steady during wait", clean_out, 1'b1);
    end
    hold(1'b1, 2);
    check("R5 after run", clean_out, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule